// File: doc/BRIEF.md
# Shared SRAM Port Arbiter with Debug Program Access

This block decides who drives a byte-wide SRAM bank that two requesters share: a port from the programmable-logic fabric and an embedded microcontroller. The microcontroller reaches the bank as flat byte-addressed data memory. It can also reach the program-code words kept in the bank through load and store accesses, one byte per access. A soft control register, reached through the microcontroller's I/O space, holds a debug bit and a bit that toggles the fabric port's enable. The enable that takes effect is the static configuration enable XORed with that toggle bit, and it is forced off while debug is set.

Program words are 16 bits wide, but the bank is 8 bits wide. A program word is therefore split over a pair of 2K-byte partitions, with the low byte in one partition and the high byte in the next. Outside debug mode, per-window write-protect configuration bits guard program stores. In debug mode those bits are ignored and any program location can be overwritten. The SRAM array itself is not part of the block. Its read data is taken combinationally for the address the block drives.

Top module: `sram_share_arb`

## Requirements
- R1: Reset (active-low `rst_n`) clears the debug and toggle bits. After reset the register reads 0x00, and `fab_port_en` equals `cfg_fab_en`.
- R2: An `io_we` pulse with `io_addr` = 0x3A loads bit 1 of `io_wdata` into the debug bit and bit 3 into the toggle bit, visible from the next cycle. A read at 0x3A returns those bits in the same positions and zero elsewhere. Writes to any other I/O address change nothing, and reads there return 0x00.
- R3: `fab_port_en` = (`cfg_fab_en` XOR toggle) AND NOT debug. `dbg_mode` shows the debug bit.
- R4: A fabric request while `fab_port_en` is 0 gets no grant and makes no SRAM access, and `fab_rdata` is 0x00.
- R5: When a microcontroller access is accepted (`mcu_ack`=1) in the same cycle as a fabric request, the microcontroller drives the SRAM and the fabric gets no grant.
- R6: A data access (`mcu_prog`=0) drives `sram_addr` with `mcu_addr` unchanged. A read returns `sram_rdata` on `mcu_rdata`.
- R7: A program access (`mcu_prog`=1) with word address W in 0x3800–0x3FFF goes to partition 0 (`mcu_hi`=0) or partition 1 (`mcu_hi`=1). W in 0x3000–0x37FF goes to partition 2 or partition 3. The byte address is partition × 0x800 + (W & 0x7FF).
- R8: Outside debug mode, a program store to window 0x3800–0x3FFF is dropped when `cfg_wp[0]`=1, and one to window 0x3000–0x37FF is dropped when `cfg_wp[1]`=1. A dropped store gives `mcu_ack`=0 and makes no SRAM access. Program loads are never blocked.
- R9: In debug mode, `cfg_wp` is ignored and every in-range program store is accepted.
- R10: A program access with a word address outside 0x3000–0x3FFF is ignored: `mcu_ack`=0, no SRAM access, and `mcu_rdata`=0x00.
- R11: With no accepted access, `sram_en`, `sram_we`, `sram_addr` and `sram_wdata` are all 0. Outputs that return data read 0x00 unless their access was granted as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low microcontroller reset |
| cfg_fab_en | input | 1 | Static fabric port enable configuration bit |
| cfg_wp | input | 2 | Program-window write-protect bits |
| io_we | input | 1 | Single-cycle I/O write strobe |
| io_addr | input | 6 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mcu_req | input | 1 | Microcontroller access request |
| mcu_we | input | 1 | Microcontroller store (1) or load (0) |
| mcu_prog | input | 1 | Program space (1) or data space (0) |
| mcu_hi | input | 1 | High byte of program word |
| mcu_addr | input | 16 | Data byte address or program word address |
| mcu_wdata | input | 8 | Microcontroller store data |
| mcu_ack | output | 1 | Microcontroller access accepted |
| mcu_rdata | output | 8 | Microcontroller load data |
| fab_req | input | 1 | Fabric access request |
| fab_we | input | 1 | Fabric write |
| fab_addr | input | 16 | Fabric byte address |
| fab_wdata | input | 8 | Fabric write data |
| fab_gnt | output | 1 | Fabric access granted |
| fab_rdata | output | 8 | Fabric read data |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 16 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |
| dbg_mode | output | 1 | Debug bit |
| fab_port_en | output | 1 | Effective fabric port enable |

## Verification
A fabric request and a microcontroller access can arrive in the same cycle. The bench provokes this by raising `fab_req` together with a data access and with program accesses, both accepted and dropped. An accepted microcontroller access must own every SRAM line while the fabric sees no grant and 0x00. A store dropped by write protection must leave the port to the fabric in that same cycle. A second overlap is a control-register write in the cycle of an access. That access must still follow the old debug and toggle values, and the new values must take effect only from the next vector.

// File: rtl/sram_share_pkg.sv
package sram_share_pkg;

    localparam int unsigned REG_W = 8;

    typedef struct packed {
        logic [REG_W-1:0] bits;
    } ctl_t;

endpackage

// File: rtl/sram_share_ctl.sv
module sram_share_ctl
    import sram_share_pkg::*;
#(
    parameter int unsigned IO_AW    = 6,
    parameter logic [IO_AW-1:0] CTL_ADDR = 6'h3A,
    parameter int unsigned DBG_BIT  = 1,
    parameter int unsigned TOG_BIT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [REG_W-1:0] io_wdata,
    output logic [REG_W-1:0] io_rdata,
    output logic             dbg,
    output logic             tog
);

    localparam logic [REG_W-1:0] WMASK = REG_W'((1 << DBG_BIT) | (1 << TOG_BIT));

    ctl_t ctl_d, ctl_q;
    logic hit;

    assign hit = (io_addr == CTL_ADDR);

    always_comb begin
        ctl_d = ctl_q;
        if (io_we && hit) begin
            ctl_d.bits = io_wdata & WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign io_rdata = hit ? ctl_q.bits : '0;
    assign dbg      = ctl_q.bits[DBG_BIT];
    assign tog      = ctl_q.bits[TOG_BIT];

    // R2: a strobed write lands in the next cycle
    assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_addr == CTL_ADDR) |=>
            (dbg == $past(io_wdata[DBG_BIT]) && tog == $past(io_wdata[TOG_BIT])));

    // R2: without a write to this address the bits hold
    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_we && io_addr == CTL_ADDR) |=> ($stable(dbg) && $stable(tog)));

endmodule

// File: rtl/sram_share_map.sv
module sram_share_map #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned PART_W   = 11,
    parameter int unsigned NUM_WIN  = 2,
    parameter int unsigned TOP_BASE = 'h3800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  word_addr,
    input  logic               hi,
    output logic [ADDR_W-1:0]  byte_addr,
    output logic [NUM_WIN-1:0] hit
);

    localparam int unsigned WIN    = 1 << PART_W;
    localparam int unsigned PIDX_W = $clog2(2 * NUM_WIN);

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(TOP_BASE - k * WIN);
        assign hit[k] = (word_addr[ADDR_W-1:PART_W] == BASE_V[ADDR_W-1:PART_W]);
    end

    logic [PIDX_W-1:0] pidx;

    always_comb begin
        pidx = '0;
        for (int k = 0; k < NUM_WIN; k++) begin
            if (hit[k]) begin
                pidx = PIDX_W'(2 * k) | PIDX_W'(hi);
            end
        end
        byte_addr = ADDR_W'({pidx, word_addr[PART_W-1:0]});
    end

    // R7: mapped bytes stay inside the program partitions
    assert_map_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (byte_addr < ADDR_W'(2 * NUM_WIN * WIN)));

endmodule

// File: rtl/sram_share_mux.sv
module sram_share_mux #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mcu_go,
    input  logic              mcu_we,
    input  logic [ADDR_W-1:0] mcu_addr,
    input  logic [DATA_W-1:0] mcu_wdata,
    output logic [DATA_W-1:0] mcu_rdata,
    input  logic              fab_en,
    input  logic              fab_req,
    input  logic              fab_we,
    input  logic [ADDR_W-1:0] fab_addr,
    input  logic [DATA_W-1:0] fab_wdata,
    output logic              fab_gnt,
    output logic [DATA_W-1:0] fab_rdata,
    output logic              sram_en,
    output logic              sram_we,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata
);

    always_comb begin
        fab_gnt    = fab_req && fab_en && !mcu_go;
        sram_en    = 1'b0;
        sram_we    = 1'b0;
        sram_addr  = '0;
        sram_wdata = '0;
        if (mcu_go) begin
            sram_en    = 1'b1;
            sram_we    = mcu_we;
            sram_addr  = mcu_addr;
            sram_wdata = mcu_wdata;
        end else if (fab_gnt) begin
            sram_en    = 1'b1;
            sram_we    = fab_we;
            sram_addr  = fab_addr;
            sram_wdata = fab_wdata;
        end
        mcu_rdata = (mcu_go && !mcu_we) ? sram_rdata : '0;
        fab_rdata = (fab_gnt && !fab_we) ? sram_rdata : '0;
    end

    // R5: never two owners
    assert_one_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fab_gnt && mcu_go));

    // R4: a disabled port is never granted
    assert_fab_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fab_en |-> (!fab_gnt && fab_rdata == '0));

    // R11: no write without an access
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_en |-> (!sram_we && sram_addr == '0));

endmodule

// File: rtl/sram_share_arb.sv
module sram_share_arb #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IO_AW    = 6,
    parameter int unsigned PART_W   = 11,
    parameter int unsigned NUM_WIN  = 2,
    parameter int unsigned TOP_BASE = 'h3800
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_fab_en,
    input  logic [NUM_WIN-1:0] cfg_wp,
    input  logic               io_we,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    input  logic               mcu_req,
    input  logic               mcu_we,
    input  logic               mcu_prog,
    input  logic               mcu_hi,
    input  logic [ADDR_W-1:0]  mcu_addr,
    input  logic [DATA_W-1:0]  mcu_wdata,
    output logic               mcu_ack,
    output logic [DATA_W-1:0]  mcu_rdata,
    input  logic               fab_req,
    input  logic               fab_we,
    input  logic [ADDR_W-1:0]  fab_addr,
    input  logic [DATA_W-1:0]  fab_wdata,
    output logic               fab_gnt,
    output logic [DATA_W-1:0]  fab_rdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [ADDR_W-1:0]  sram_addr,
    output logic [DATA_W-1:0]  sram_wdata,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic               dbg_mode,
    output logic               fab_port_en
);

    logic               dbg, tog;
    logic [ADDR_W-1:0]  map_addr;
    logic [NUM_WIN-1:0] win_hit;
    logic               prog_ok;
    logic [ADDR_W-1:0]  route_addr;

    sram_share_ctl #(
        .IO_AW (IO_AW)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_we    (io_we),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .dbg      (dbg),
        .tog      (tog)
    );

    sram_share_map #(
        .ADDR_W   (ADDR_W),
        .PART_W   (PART_W),
        .NUM_WIN  (NUM_WIN),
        .TOP_BASE (TOP_BASE)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_addr (mcu_addr),
        .hi        (mcu_hi),
        .byte_addr (map_addr),
        .hit       (win_hit)
    );

    always_comb begin
        prog_ok     = (|win_hit) && (!mcu_we || dbg || !(|(cfg_wp & win_hit)));
        mcu_ack     = mcu_req && (mcu_prog ? prog_ok : 1'b1);
        route_addr  = mcu_prog ? map_addr : mcu_addr;
        fab_port_en = (cfg_fab_en ^ tog) && !dbg;
        dbg_mode    = dbg;
    end

    sram_share_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .mcu_go     (mcu_ack),
        .mcu_we     (mcu_we),
        .mcu_addr   (route_addr),
        .mcu_wdata  (mcu_wdata),
        .mcu_rdata  (mcu_rdata),
        .fab_en     (fab_port_en),
        .fab_req    (fab_req),
        .fab_we     (fab_we),
        .fab_addr   (fab_addr),
        .fab_wdata  (fab_wdata),
        .fab_gnt    (fab_gnt),
        .fab_rdata  (fab_rdata),
        .sram_en    (sram_en),
        .sram_we    (sram_we),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_rdata (sram_rdata)
    );

    // R3: debug shuts the fabric port
    assert_dbg_blocks_fab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> !fab_gnt);

    // R9: debug accepts every in-range program access
    assert_dbg_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && mcu_req && mcu_prog && mcu_addr[ADDR_W-1:PART_W+1] == ADDR_W'(TOP_BASE) >> (PART_W+1))
            |-> mcu_ack);

    // R10: out-of-range program words are refused
    assert_prog_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_prog && win_hit == '0) |-> (!mcu_ack && mcu_rdata == '0));

endmodule

// File: tb/sram_share_arb_tb.sv
module sram_share_arb_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk, rst_n;
    logic        cfg_fab_en;
    logic [1:0]  cfg_wp;
    logic        io_we;
    logic [5:0]  io_addr;
    logic [7:0]  io_wdata, io_rdata;
    logic        mcu_req, mcu_we, mcu_prog, mcu_hi, mcu_ack;
    logic [15:0] mcu_addr;
    logic [7:0]  mcu_wdata, mcu_rdata;
    logic        fab_req, fab_we, fab_gnt;
    logic [15:0] fab_addr;
    logic [7:0]  fab_wdata, fab_rdata;
    logic        sram_en, sram_we;
    logic [15:0] sram_addr;
    logic [7:0]  sram_wdata, sram_rdata;
    logic        dbg_mode, fab_port_en;

    sram_share_arb u_dut (.*);

    // array stand-in: data is a fixed function of the address
    assign sram_rdata = sram_addr[7:0] ^ sram_addr[15:8] ^ 8'hA5;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [53:0] val;
        string       tag;
    } exp_t;

    exp_t   sb_q[$];
    event   mon_ev;
    int     n_vec = 0;
    int     n_bad = 0;
    logic   md_dbg = 1'b0;
    logic   md_tog = 1'b0;
    bit     done   = 1'b0;

    function automatic logic [7:0] arr(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [53:0] model();
        logic        pen, ack, gnt, en, we, inr, prot;
        logic [15:0] a, b, ma;
        logic [7:0]  wd, mrd, frd, ird;
        pen = (cfg_fab_en ^ md_tog) & ~md_dbg;
        ack = 1'b0; ma = 16'h0; b = 16'h0; inr = 1'b0; prot = 1'b0;
        if (mcu_req) begin
            if (!mcu_prog) begin
                ack = 1'b1; ma = mcu_addr;
            end else begin
                if (mcu_addr >= 16'h3800 && mcu_addr <= 16'h3FFF) begin
                    inr = 1'b1; prot = cfg_wp[0];
                    b = (mcu_hi ? 16'h0800 : 16'h0000) + (mcu_addr & 16'h07FF);
                end else if (mcu_addr >= 16'h3000 && mcu_addr <= 16'h37FF) begin
                    inr = 1'b1; prot = cfg_wp[1];
                    b = (mcu_hi ? 16'h1800 : 16'h1000) + (mcu_addr & 16'h07FF);
                end
                ack = inr && (!mcu_we || md_dbg || !prot);
                ma = b;
            end
        end
        gnt = fab_req && pen && !ack;
        en = ack || gnt;
        we = 1'b0; a = 16'h0; wd = 8'h0;
        if (ack) begin we = mcu_we; a = ma; wd = mcu_wdata; end
        else if (gnt) begin we = fab_we; a = fab_addr; wd = fab_wdata; end
        mrd = (ack && !mcu_we) ? arr(a) : 8'h00;
        frd = (gnt && !fab_we) ? arr(a) : 8'h00;
        ird = (io_addr == 6'h3A) ? {4'b0, md_tog, 1'b0, md_dbg, 1'b0} : 8'h00;
        return {en, we, a, wd, gnt, frd, ack, mrd, ird, pen, md_dbg};
    endfunction

    task automatic vec(input logic cfg, input logic [1:0] wp,
                       input logic iwe, input logic [5:0] ia, input logic [7:0] iwd,
                       input logic mr, input logic mw, input logic mp, input logic mh,
                       input logic [15:0] ma, input logic [7:0] mwd,
                       input logic fr, input logic fw, input logic [15:0] fa,
                       input logic [7:0] fwd, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_fab_en = cfg; cfg_wp = wp;
        io_we = iwe; io_addr = ia; io_wdata = iwd;
        mcu_req = mr; mcu_we = mw; mcu_prog = mp; mcu_hi = mh; mcu_addr = ma; mcu_wdata = mwd;
        fab_req = fr; fab_we = fw; fab_addr = fa; fab_wdata = fwd;
        #1;
        e.val = model();
        e.tag = tag;
        sb_q.push_back(e);
        -> mon_ev;
        if (iwe && ia == 6'h3A) begin
            md_dbg = iwd[1];
            md_tog = iwd[3];
        end
    endtask

    task automatic idle(input logic cfg, input string tag);
        vec(cfg, 2'b00, 0, 6'h3A, 8'h00, 0, 0, 0, 0, 16'h0, 8'h0, 0, 0, 16'h0, 8'h0, tag);
    endtask

    task automatic ctl_wr(input logic [7:0] d, input string tag);
        vec(1'b1, 2'b00, 1, 6'h3A, d, 0, 0, 0, 0, 16'h0, 8'h0, 0, 0, 16'h0, 8'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        io_we = 1'b0; mcu_req = 1'b0; fab_req = 1'b0;
        md_dbg = 1'b0; md_tog = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [53:0] act;
                e = sb_q.pop_front();
                act = {sram_en, sram_we, sram_addr, sram_wdata, fab_gnt, fab_rdata,
                       mcu_ack, mcu_rdata, io_rdata, fab_port_en, dbg_mode};
                n_vec++;
                if (act !== e.val) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_fab_en = 1'b0; cfg_wp = 2'b00;
        io_we = 1'b0; io_addr = 6'h0; io_wdata = 8'h0;
        mcu_req = 1'b0; mcu_we = 1'b0; mcu_prog = 1'b0; mcu_hi = 1'b0;
        mcu_addr = 16'h0; mcu_wdata = 8'h0;
        fab_req = 1'b0; fab_we = 1'b0; fab_addr = 16'h0; fab_wdata = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        idle(1'b1, "R1 reset state, enable follows config");
        idle(1'b0, "R11 idle lines quiet");
        vec(0, 2'b00, 0, 6'h00, 8'h0, 1, 1, 0, 0, 16'h1234, 8'h77, 0, 0, 16'h0, 8'h0, "R6 data store 1:1");
        vec(0, 2'b00, 0, 6'h00, 8'h0, 1, 0, 0, 0, 16'h0ABC, 8'h00, 0, 0, 16'h0, 8'h0, "R6 data load 1:1");
        vec(0, 2'b00, 0, 6'h00, 8'h0, 0, 0, 0, 0, 16'h0, 8'h0, 1, 0, 16'h2345, 8'h0, "R4 fabric ignored when disabled");
        vec(1, 2'b00, 0, 6'h00, 8'h0, 0, 0, 0, 0, 16'h0, 8'h0, 1, 0, 16'h2345, 8'h0, "R3 fabric read granted");
        vec(1, 2'b00, 0, 6'h00, 8'h0, 0, 0, 0, 0, 16'h0, 8'h0, 1, 1, 16'h0333, 8'h5C, "R3 fabric write granted");
        vec(1, 2'b00, 0, 6'h00, 8'h0, 1, 0, 0, 0, 16'h4444, 8'h0, 1, 0, 16'h2345, 8'h0, "R5 mcu wins same cycle");
        ctl_wr(8'hF8, "R2 toggle write, old state still used");
        idle(1'b1, "R2 readback toggle only, R3 enable inverted");
        vec(1, 2'b00, 1, 6'h3B, 8'hFF, 0, 0, 0, 0, 16'h0, 8'h0, 1, 0, 16'h0100, 8'h0, "R4 toggled port off");
        vec(0, 2'b00, 0, 6'h3B, 8'h00, 0, 0, 0, 0, 16'h0, 8'h0, 1, 0, 16'h0100, 8'h0, "R2 other address reads zero, R3 toggle enables");
        idle(1'b0, "R2 write to other address ignored");
        ctl_wr(8'h02, "R2 debug write");
        vec(1, 2'b00, 0, 6'h3A, 8'h0, 0, 0, 0, 0, 16'h0, 8'h0, 1, 0, 16'h0100, 8'h0, "R3 debug forces port off");
        vec(1, 2'b11, 0, 6'h3A, 8'h0, 1, 1, 1, 0, 16'h3805, 8'h11, 1, 0, 16'h0100, 8'h0, "R7 R9 word 0x3805 low byte");
        vec(1, 2'b11, 0, 6'h3A, 8'h0, 1, 1, 1, 1, 16'h3805, 8'h22, 0, 0, 16'h0, 8'h0, "R7 R9 word 0x3805 high byte");
        vec(1, 2'b11, 0, 6'h3A, 8'h0, 1, 1, 1, 0, 16'h3123, 8'h33, 0, 0, 16'h0, 8'h0, "R7 R9 word 0x3123 low byte");
        vec(1, 2'b11, 0, 6'h3A, 8'h0, 1, 0, 1, 1, 16'h3123, 8'h00, 0, 0, 16'h0, 8'h0, "R7 word 0x3123 high byte load");
        vec(1, 2'b11, 0, 6'h3A, 8'h0, 1, 0, 1, 1, 16'h3FFF, 8'h00, 0, 0, 16'h0, 8'h0, "R7 top word high byte");
        vec(1, 2'b11, 0, 6'h3A, 8'h0, 1, 0, 1, 0, 16'h3000, 8'h00, 0, 0, 16'h0, 8'h0, "R7 bottom word low byte");
        vec(1, 2'b00, 0, 6'h3A, 8'h0, 1, 0, 1, 0, 16'h4000, 8'h00, 0, 0, 16'h0, 8'h0, "R10 word above range ignored");
        vec(1, 2'b00, 0, 6'h3A, 8'h0, 1, 1, 1, 1, 16'h2FFF, 8'h9A, 0, 0, 16'h0, 8'h0, "R10 word below range ignored");
        ctl_wr(8'h00, "R2 debug clear");
        vec(1, 2'b01, 0, 6'h3A, 8'h0, 1, 1, 1, 0, 16'h3805, 8'h44, 0, 0, 16'h0, 8'h0, "R8 protected upper window store dropped");
        vec(1, 2'b10, 0, 6'h3A, 8'h0, 1, 1, 1, 0, 16'h3805, 8'h44, 0, 0, 16'h0, 8'h0, "R8 upper window store allowed");
        vec(1, 2'b10, 0, 6'h3A, 8'h0, 1, 1, 1, 1, 16'h3456, 8'h55, 0, 0, 16'h0, 8'h0, "R8 protected lower window store dropped");
        vec(1, 2'b11, 0, 6'h3A, 8'h0, 1, 0, 1, 0, 16'h3100, 8'h00, 0, 0, 16'h0, 8'h0, "R8 protected load still served");
        vec(1, 2'b01, 0, 6'h3A, 8'h0, 1, 1, 1, 0, 16'h3900, 8'h66, 1, 0, 16'h0777, 8'h0, "R8 R5 dropped store leaves port to fabric");
        ctl_wr(8'h0A, "R2 set both bits");
        idle(1'b1, "R2 both bits read back");
        do_reset();
        idle(1'b1, "R1 reset clears toggle and debug");

        repeat (2) @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule